// File: doc/BRIEF.md
# Flag-Generating Saturating ALU

This block is a 32-bit integer arithmetic/logic unit that sits between a register file and a status word. Each accepted operation produces a result, a write-enable for the register file and an update of five status flags: zero, sign, carry, overflow and a sticky saturation flag. The arithmetic group covers add, subtract, reverse subtract, compare, saturating add and saturating subtract. The logical group covers OR, AND, XOR and NOT.

The destination-side operand `b_i` is always a register value. The source-side operand is picked by `src_sel_i` from the register value `a_i` or from an immediate in `imm_i`. Saturating operations clamp an overflowing result to the nearest signed limit and set the sticky flag. That flag is only cleared by reset. The result, the write-enable and the status word are registered, so they appear one clock after `valid_i`.

Top module: `alu_flagsat`

## Requirements
- R1: While `rst_ni` is low and after its release, `result_o`, `wr_en_o` and `flags_o` are zero until the first accepted operation. `flags_o` bit layout: 0=Z, 1=S, 2=CY, 3=OV, 4=SAT.
- R2: Source operand selection by `src_sel_i`:
  - 0 takes `a_i`.
  - 1 sign-extends `imm_i[4:0]`.
  - 2 sign-extends `imm_i[15:0]`.
  - 3 zero-extends `imm_i[15:0]`.
- R3: Add (op 0) and saturating add (op 4) form b+src. CY is the unsigned carry out. OV is set when both operands share a sign bit that the sum does not.
- R4: Subtract (op 1) forms b−src and reverse subtract (op 2) forms src−b. CY is the unsigned borrow (minuend < subtrahend). OV is set when the operand signs differ and the result sign differs from the minuend's.
- R5: Compare (op 3) updates Z, S, CY and OV exactly as subtract does, and the following cycle shows `wr_en_o` low with `result_o` unchanged.
- R6: Saturating subtract (op 5) forms b−src. When a saturating operation overflows, the result is 0x7FFFFFFF if the exact result is positive and 0x80000000 if it is negative, and SAT is set.
- R7: SAT is never cleared by any operation; once set it stays set until reset.
- R8: OR (op 6), AND (op 7), XOR (op 8) and NOT (op 9, result ~src) set Z and S from the result, clear OV, and keep CY and SAT.
- R9: AND with a 16-bit immediate (`src_sel_i` 2 or 3) sets Z from the result, clears S and OV, and keeps CY and SAT.
- R10: All outputs change one clock after an accepted operation. When `valid_i` is low or the opcode is 10..15, `wr_en_o` is low in the next cycle and `result_o` and `flags_o` hold.
- R11: For all arithmetic operations Z and S describe the wrapped 32-bit result before any clamping. `wr_en_o` is high after every accepted operation other than compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation accepted this cycle |
| op_i | input | 4 | Operation code |
| src_sel_i | input | 2 | Source operand select |
| a_i | input | 32 | Source register value |
| b_i | input | 32 | Destination register value |
| imm_i | input | 16 | Immediate field |
| result_o | output | 32 | Registered result |
| wr_en_o | output | 1 | Register file write enable for `result_o` |
| flags_o | output | 5 | Status word {SAT, OV, CY, S, Z} |

## Verification
The status word is state, so a wrong flag does not always show at once. A corrupted CY appears only at the next logical operation, which must carry it through unchanged. A lost SAT appears at any later cycle, because the bit must never fall. The bench therefore compares every output after every operation, including idle cycles, against a running model. A divergence in the flag register is reported in the cycle it occurs rather than at some later consumer.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD    = 4'd0,
    OP_SUB    = 4'd1,
    OP_SUBR   = 4'd2,
    OP_CMP    = 4'd3,
    OP_SATADD = 4'd4,
    OP_SATSUB = 4'd5,
    OP_OR     = 4'd6,
    OP_AND    = 4'd7,
    OP_XOR    = 4'd8,
    OP_NOT    = 4'd9
  } alu_op_e;

  typedef enum logic [1:0] {
    SRC_REG    = 2'd0,
    SRC_SIMM_S = 2'd1,
    SRC_SIMM_L = 2'd2,
    SRC_UIMM_L = 2'd3
  } src_sel_e;

  typedef struct packed {
    logic sat;
    logic ov;
    logic cy;
    logic s;
    logic z;
  } flags_t;

  localparam int unsigned FLAG_W = $bits(flags_t);
endpackage

// File: rtl/alu_opnd_sel.sv
module alu_opnd_sel #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SHORT_W = 5,
  parameter int unsigned LONG_W  = 16
) (
  input  logic [1:0]        src_sel_i,
  input  logic [DATA_W-1:0] reg_i,
  input  logic [LONG_W-1:0] imm_i,
  output logic [DATA_W-1:0] opnd_o
);
  import alu_pkg::*;

  localparam int unsigned SHORT_PAD = DATA_W - SHORT_W;
  localparam int unsigned LONG_PAD  = DATA_W - LONG_W;

  logic [DATA_W-1:0] simm_s, simm_l, uimm_l;

  assign simm_s = {{SHORT_PAD{imm_i[SHORT_W-1]}}, imm_i[SHORT_W-1:0]};
  assign simm_l = {{LONG_PAD{imm_i[LONG_W-1]}}, imm_i};
  assign uimm_l = {{LONG_PAD{1'b0}}, imm_i};

  always_comb begin
    unique case (src_sel_e'(src_sel_i))
      SRC_SIMM_S: opnd_o = simm_s;
      SRC_SIMM_L: opnd_o = simm_l;
      SRC_UIMM_L: opnd_o = uimm_l;
      default:    opnd_o = reg_i;
    endcase
  end
endmodule

// File: rtl/alu_arith.sv
module alu_arith #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] dst_i,   // destination-side operand
  input  logic [DATA_W-1:0] src_i,   // selected source operand
  output logic [DATA_W-1:0] raw_o,   // wrapped result, pre-clamp
  output logic [DATA_W-1:0] res_o,   // result after clamping
  output logic              cy_o,
  output logic              ov_o,
  output logic              sat_o
);
  import alu_pkg::*;

  localparam int unsigned MSB = DATA_W - 1;
  localparam logic [DATA_W-1:0] NEG_LIM = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] POS_LIM = ~NEG_LIM;

  logic              is_add, is_sat;
  logic [DATA_W-1:0] lhs, rhs;
  logic [DATA_W:0]   wide;

  always_comb begin
    is_add = (op_i == OP_ADD) || (op_i == OP_SATADD);
    is_sat = (op_i == OP_SATADD) || (op_i == OP_SATSUB);
    // reverse subtract swaps minuend and subtrahend
    lhs = (op_i == OP_SUBR) ? src_i : dst_i;
    rhs = (op_i == OP_SUBR) ? dst_i : src_i;
    if (is_add) wide = {1'b0, lhs} + {1'b0, rhs};
    else        wide = {1'b0, lhs} - {1'b0, rhs};
    raw_o = wide[DATA_W-1:0];
    cy_o  = wide[DATA_W];
    if (is_add) ov_o = (lhs[MSB] == rhs[MSB]) && (raw_o[MSB] != lhs[MSB]);
    else        ov_o = (lhs[MSB] != rhs[MSB]) && (raw_o[MSB] != lhs[MSB]);
    sat_o = is_sat && ov_o;
    // on overflow the exact result carries the sign of lhs
    if (sat_o) res_o = lhs[MSB] ? NEG_LIM : POS_LIM;
    else       res_o = raw_o;
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  output logic [DATA_W-1:0] res_o
);
  import alu_pkg::*;

  always_comb begin
    unique case (op_i)
      OP_OR:   res_o = dst_i | src_i;
      OP_AND:  res_o = dst_i & src_i;
      OP_XOR:  res_o = dst_i ^ src_i;
      default: res_o = ~src_i;
    endcase
  end
endmodule

// File: rtl/alu_flagsat.sv
module alu_flagsat #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SHORT_W = 5,
  parameter int unsigned LONG_W  = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      valid_i,
  input  logic [3:0]                op_i,
  input  logic [1:0]                src_sel_i,
  input  logic [DATA_W-1:0]         a_i,
  input  logic [DATA_W-1:0]         b_i,
  input  logic [LONG_W-1:0]         imm_i,
  output logic [DATA_W-1:0]         result_o,
  output logic                      wr_en_o,
  output logic [alu_pkg::FLAG_W-1:0] flags_o
);
  import alu_pkg::*;

  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W-1:0] src_val, a_raw, a_res, l_res;
  logic              a_cy, a_ov, a_sat;
  logic              is_arith, is_logic, is_cmp, and_long;
  flags_t            flg_q, flg_d;
  logic [DATA_W-1:0] res_q, res_d;
  logic              wr_q, wr_d;

  alu_opnd_sel #(.DATA_W(DATA_W), .SHORT_W(SHORT_W), .LONG_W(LONG_W)) u_sel (
    .src_sel_i(src_sel_i),
    .reg_i    (a_i),
    .imm_i    (imm_i),
    .opnd_o   (src_val)
  );

  alu_arith #(.DATA_W(DATA_W)) u_arith (
    .op_i (op_i),
    .dst_i(b_i),
    .src_i(src_val),
    .raw_o(a_raw),
    .res_o(a_res),
    .cy_o (a_cy),
    .ov_o (a_ov),
    .sat_o(a_sat)
  );

  alu_logic #(.DATA_W(DATA_W)) u_logic (
    .op_i (op_i),
    .dst_i(b_i),
    .src_i(src_val),
    .res_o(l_res)
  );

  always_comb begin
    is_arith = op_i <= OP_SATSUB;
    is_logic = (op_i >= OP_OR) && (op_i <= OP_NOT);
    is_cmp   = op_i == OP_CMP;
    and_long = (op_i == OP_AND) &&
               ((src_sel_i == SRC_SIMM_L) || (src_sel_i == SRC_UIMM_L));
  end

  always_comb begin
    flg_d = flg_q;
    res_d = res_q;
    wr_d  = 1'b0;
    if (valid_i && is_arith) begin
      flg_d.z   = a_raw == '0;
      flg_d.s   = a_raw[MSB];
      flg_d.cy  = a_cy;
      flg_d.ov  = a_ov;
      flg_d.sat = flg_q.sat | a_sat;
      if (!is_cmp) begin
        res_d = a_res;
        wr_d  = 1'b1;
      end
    end else if (valid_i && is_logic) begin
      flg_d.z  = l_res == '0;
      flg_d.s  = and_long ? 1'b0 : l_res[MSB];
      flg_d.ov = 1'b0;
      res_d    = l_res;
      wr_d     = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flg_q <= '0;
      res_q <= '0;
      wr_q  <= 1'b0;
    end else begin
      flg_q <= flg_d;
      res_q <= res_d;
      wr_q  <= wr_d;
    end
  end

  assign result_o = res_q;
  assign wr_en_o  = wr_q;
  assign flags_o  = flg_q;
endmodule

// File: rtl/alu_flagsat_chk.sv
module alu_flagsat_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [3:0]        op_i,
  input logic [1:0]        src_sel_i,
  input logic [DATA_W-1:0] result_o,
  input logic              wr_en_o,
  input logic [4:0]        flags_o
);
  import alu_pkg::*;

  localparam logic [DATA_W-1:0] NEG_LIM = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] POS_LIM = ~NEG_LIM;

  logic logic_op, sat_op, long_sel;
  assign logic_op = (op_i >= OP_OR) && (op_i <= OP_NOT);
  assign sat_op   = (op_i == OP_SATADD) || (op_i == OP_SATSUB);
  assign long_sel = (src_sel_i == SRC_SIMM_L) || (src_sel_i == SRC_UIMM_L);

  AST_SAT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[4] |=> flags_o[4]); // R7

  AST_CMP_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_CMP |=> !wr_en_o && $stable(result_o)); // R5

  AST_LOGIC_OV_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && logic_op |=> !flags_o[3]); // R8

  AST_LOGIC_CY_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && logic_op |=> flags_o[2] == $past(flags_o[2])); // R8

  AST_ANDI_SIGN_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_AND && long_sel |=> !flags_o[1]); // R9

  AST_SAT_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && sat_op |=> !flags_o[3] || result_o == POS_LIM || result_o == NEG_LIM); // R6

  AST_SAT_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && sat_op |=> !flags_o[3] || flags_o[4]); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !wr_en_o && $stable(result_o) && $stable(flags_o)); // R10

  AST_LOGIC_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && logic_op |=> flags_o[0] == (result_o == '0)); // R8
endmodule

bind alu_flagsat alu_flagsat_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .op_i     (op_i),
  .src_sel_i(src_sel_i),
  .result_o (result_o),
  .wr_en_o  (wr_en_o),
  .flags_o  (flags_o)
);

// File: tb/alu_flagsat_tb.sv
module alu_flagsat_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [1:0]  src_sel_i = '0;
  logic [31:0] a_i = '0, b_i = '0;
  logic [15:0] imm_i = '0;
  logic [31:0] result_o;
  logic        wr_en_o;
  logic [4:0]  flags_o;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] m_res = '0;
  logic        m_wr = 1'b0;
  logic [4:0]  m_flg = '0;

  always #10 clk_i = ~clk_i;

  alu_flagsat u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .src_sel_i(src_sel_i), .a_i(a_i), .b_i(b_i), .imm_i(imm_i),
    .result_o(result_o), .wr_en_o(wr_en_o), .flags_o(flags_o)
  );

  function automatic string req_of(input logic [3:0] op, input logic [1:0] src);
    case (op)
      4'd0, 4'd4: return "R3";
      4'd1, 4'd2: return "R4";
      4'd3:       return "R5";
      4'd5:       return "R6";
      4'd7:       return (src >= 2) ? "R9" : "R8";
      4'd6, 4'd8, 4'd9: return "R8";
      default:    return "R10";
    endcase
  endfunction

  function automatic logic [31:0] src_of(input logic [1:0] s, input logic [31:0] a,
                                          input logic [15:0] imm);
    case (s)
      2'd0: return a;
      2'd1: return {{27{imm[4]}}, imm[4:0]};
      2'd2: return {{16{imm[15]}}, imm};
      default: return {16'h0, imm};
    endcase
  endfunction

  task automatic model(input logic v, input logic [3:0] op, input logic [1:0] s,
                       input logic [31:0] a, input logic [31:0] b, input logic [15:0] imm);
    logic [31:0] x, w;
    longint signed exact;
    longint unsigned ux;
    logic c, o;
    m_wr = 1'b0;
    if (!v || op > 4'd9) return;
    x = src_of(s, a, imm);
    if (op <= 4'd5) begin
      case (op)
        4'd0, 4'd4: begin
          exact = longint'($signed(b)) + longint'($signed(x));
          ux = longint'(b) + longint'(x);
          w = b + x; c = ux > 64'hFFFF_FFFF;
        end
        4'd2: begin
          exact = longint'($signed(x)) - longint'($signed(b));
          w = x - b; c = x < b;
        end
        default: begin
          exact = longint'($signed(b)) - longint'($signed(x));
          w = b - x; c = b < x;
        end
      endcase
      o = (exact > 64'sd2147483647) || (exact < -64'sd2147483648);
      m_flg[0] = (w == 0); m_flg[1] = w[31]; m_flg[2] = c; m_flg[3] = o;
      if (op != 4'd3) begin
        m_wr = 1'b1;
        m_res = w;
        if ((op == 4'd4 || op == 4'd5) && o) begin
          m_res = (exact > 0) ? 32'h7FFF_FFFF : 32'h8000_0000;
          m_flg[4] = 1'b1;
        end
      end
    end else begin
      case (op)
        4'd6: w = b | x;
        4'd7: w = b & x;
        4'd8: w = b ^ x;
        default: w = ~x;
      endcase
      m_wr = 1'b1; m_res = w;
      m_flg[0] = (w == 0);
      m_flg[1] = (op == 4'd7 && s >= 2) ? 1'b0 : w[31];
      m_flg[3] = 1'b0;
    end
  endtask

  task automatic check(input string tag);
    checks++;
    if (result_o !== m_res || wr_en_o !== m_wr || flags_o !== m_flg) begin
      errors++;
      $display("FAIL %s: res=%h wr=%b flags=%b expected res=%h wr=%b flags=%b",
               tag, result_o, wr_en_o, flags_o, m_res, m_wr, m_flg);
    end
  endtask

  // called at a falling edge; returns at the next falling edge after checking
  task automatic run(input logic v, input logic [3:0] op, input logic [1:0] s,
                     input logic [31:0] a, input logic [31:0] b, input logic [15:0] imm,
                     input string tag);
    valid_i = v; op_i = op; src_sel_i = s; a_i = a; b_i = b; imm_i = imm;
    model(v, op, s, a, b, imm);
    @(negedge clk_i);
    check(tag == "" ? req_of(op, s) : tag);
  endtask

  function automatic logic [31:0] pick();
    case ($urandom_range(0, 7))
      0: return 32'h0;
      1: return 32'h1;
      2: return 32'hFFFF_FFFF;
      3: return 32'h7FFF_FFFF;
      4: return 32'h8000_0000;
      default: return $urandom();
    endcase
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    check("R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1");

    // R2 immediate forms
    run(1, 4'd0, 2'd1, 32'h0, 32'd100, 16'h001F, "R2");   // +(-1)
    run(1, 4'd0, 2'd2, 32'h0, 32'd0, 16'h8000, "R2");     // -32768
    run(1, 4'd6, 2'd3, 32'h0, 32'h0, 16'h8000, "R2");     // zero-extended
    // R3 carry and overflow
    run(1, 4'd0, 2'd0, 32'hFFFF_FFFF, 32'h1, 16'h0, "R3");
    run(1, 4'd0, 2'd0, 32'h7FFF_FFFF, 32'h1, 16'h0, "R3");
    // R4 subtract and reverse subtract
    run(1, 4'd1, 2'd0, 32'h1, 32'h0, 16'h0, "R4");
    run(1, 4'd1, 2'd0, 32'h1, 32'h8000_0000, 16'h0, "R4");
    run(1, 4'd2, 2'd0, 32'h5, 32'h3, 16'h0, "R4");
    // R5 compare keeps result
    run(1, 4'd3, 2'd0, 32'h9, 32'h9, 16'h0, "R5");
    // R8 logic keeps carry (set it first), clears OV
    run(1, 4'd0, 2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0, "R3");
    run(1, 4'd9, 2'd0, 32'h0, 32'h0, 16'h0, "R8");
    // R9 and-immediate: S cleared though b is negative
    run(1, 4'd7, 2'd2, 32'h0, 32'hFFFF_FFFF, 16'h8001, "R9");
    // R6, R11 saturation, Z from raw sum
    run(1, 4'd4, 2'd0, 32'h8000_0000, 32'h8000_0000, 16'h0, "R11");
    run(1, 4'd5, 2'd0, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 16'h0, "R6");
    // R7 sticky SAT through a clean add
    run(1, 4'd0, 2'd0, 32'h1, 32'h1, 16'h0, "R7");
    // R10 idle and undefined opcode
    run(0, 4'd0, 2'd0, 32'h5, 32'h5, 16'h0, "R10");
    run(1, 4'd12, 2'd0, 32'h5, 32'h5, 16'h0, "R10");

    // reset again to clear SAT, then mixed random traffic
    rst_ni = 1'b0; m_res = '0; m_wr = 1'b0; m_flg = '0;
    @(negedge clk_i);
    check("R1");
    rst_ni = 1'b1;
    for (int i = 0; i < 600; i++) begin
      logic v;
      logic [3:0] op;
      v  = ($urandom_range(0, 9) != 0);
      op = 4'($urandom_range(0, 10));
      run(v, op, 2'($urandom_range(0, 3)), pick(), pick(), 16'($urandom()), "");
    end
    summary();
  end
endmodule